// File: doc/BRIEF.md
# Glitch-Free Clock Source Switch and Prescaler

This block builds the system clock from one of three free-running inputs: a fast internal oscillator, a slow internal oscillator, or an external clock pin. A glitch-free multiplexer picks one of them to form the main clock. A prescaler then divides the main clock by a power of two, from 1 to 256, to make the system clock. A single write port sets a 2-bit source code and a 4-bit divide code. The write port is clocked by the fast oscillator, which keeps running in every mode. A ready output reports when the requested source and ratio are both in effect.

The multiplexer uses a two-stage enable chain on each input. The first stage is clocked on the rising edge of that input, and the second on its falling edge. An input can only be enabled after every other input's enable has dropped, so one source at most drives the main clock. The prescaler does not toggle a divided flop. Instead it gates whole main-clock high phases through an enable that is updated on the falling edge. Ratio 1 is therefore a gate that stays open. A new ratio is loaded only when the counter wraps, so a period already in progress always finishes at its old length.

Top module: `clk_switch_div`

## Requirements
- R1: After a synchronous active-low reset, the fast oscillator is selected and the ratio is 8 (divide code 3). The system clock period is then eight fast periods, and ready is low while reset is held.
- R2: Source code 0 selects the fast oscillator, code 1 the slow oscillator and code 2 the external clock. The system period follows the chosen source's period times the ratio.
- R3: A write with source code 3 leaves the current source unchanged.
- R4: Divide codes 0 to 8 set the ratio to 2 to the power of the code (1 to 256). The counter counts main-clock cycles.
- R5: A write with a divide code from 9 to 15 leaves the current ratio unchanged.
- R6: While the source changes, no system clock period is shorter than the shorter of the old and new periods.
- R7: At most one source is enabled onto the main clock at any time. No system clock high phase is shorter than half the period of the faster of the two sources involved.
- R8: While only the ratio changes, every system clock period is either exactly the old period or exactly the new one. The new ratio is loaded only when the counter wraps.
- R9: Ready goes low in the cycle after any write. It rises again once the requested source is the only one enabled and the requested ratio is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast internal oscillator; also clocks the write port and reset |
| clk_slow | input | 1 | Slow internal oscillator |
| clk_ext | input | 1 | External clock input |
| rst_n | input | 1 | Synchronous active-low reset, timed to clk_fast |
| wr_en | input | 1 | Write strobe, one clk_fast cycle |
| wr_src | input | 2 | Source code: 0 fast, 1 slow, 2 external, 3 reserved |
| wr_div | input | 4 | Divide code 0..8 (ratio 2^code); 9..15 ignored |
| sys_clk | output | 1 | Divided, glitch-free system clock |
| ready | output | 1 | Requested source and ratio are in effect |

## Verification
The assertions assume the following about the inputs:
- All three source clocks run continuously with a 50 % duty cycle.
- Reset is held for several periods of the slowest source, so every enable chain sees it.
- A new write arrives only after the previous divide code has been stable for at least three main-clock cycles.

The bench meets these conditions. It runs all three clocks throughout, at 8, 40 and 24 ns with an offset phase on the external clock. It holds reset for 30 fast cycles. It issues each write only after ready has returned and several system periods have passed. It tracks the shortest period and the shortest high phase across every change, and compares them with the bounds in the requirements.

// File: rtl/ckctl_pkg.sv
// Package: shared widths, source codes and reset values for the clock
// switch and prescaler. Assumes exactly three sources and ratios up to 2^DIV_MAX.
package ckctl_pkg;
    localparam int SRC_W   = 2;
    localparam int DIV_W   = 4;
    localparam int NUM_SRC = 3;
    localparam int DIV_MAX = 8;
    localparam int CNT_W   = DIV_MAX;
    localparam logic [DIV_W-1:0] DIV_RST = DIV_W'(3);

    typedef enum logic [SRC_W-1:0] {
        SRC_FAST = 2'd0,
        SRC_SLOW = 2'd1,
        SRC_EXT  = 2'd2,
        SRC_RSVD = 2'd3
    } src_e;
endpackage

// File: rtl/ckctl_cfg.sv
// Configuration holder in the fast-oscillator domain. It keeps the requested
// source and divide code, drops writes that carry reserved or out-of-range
// fields, and raises ready once the mux and prescaler report the request as
// applied. Assumes en_ack and div_act come from other domains and resyncs them.
module ckctl_cfg import ckctl_pkg::*; (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SRC_W-1:0]   wr_src,
    input  logic [DIV_W-1:0]   wr_div,
    input  logic [NUM_SRC-1:0] en_ack,
    input  logic [DIV_W-1:0]   div_act,
    output logic [SRC_W-1:0]   sel,
    output logic [DIV_W-1:0]   div_code,
    output logic               ready
);
    logic               src_ok;
    logic               div_ok;
    logic [NUM_SRC-1:0] sel_oh;
    logic               applied;
    logic               rdy_s1;
    logic               rdy_s2;

    // Field validity and the applied-state comparison.
    always_comb begin
        src_ok  = (wr_src < SRC_W'(NUM_SRC));
        div_ok  = (wr_div <= DIV_W'(DIV_MAX));
        sel_oh  = NUM_SRC'(1) << sel;
        applied = (en_ack == sel_oh) && (div_act == div_code);
    end

    // Request registers: each field updates only when it is legal.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel      <= SRC_FAST;
            div_code <= DIV_RST;
        end else if (wr_en) begin
            if (src_ok) sel      <= wr_src;
            if (div_ok) div_code <= wr_div;
        end
    end

    // Ready synchroniser, flushed by every write.
    always_ff @(posedge clk) begin
        if (!rst_n || wr_en) begin
            rdy_s1 <= 1'b0;
            rdy_s2 <= 1'b0;
        end else begin
            rdy_s1 <= applied;
            rdy_s2 <= rdy_s1;
        end
    end

    assign ready = rdy_s2;

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (sel == SRC_FAST && div_code == DIV_RST && !ready));

    p_rsvd_src_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_src == SRC_RSVD) |=> $stable(sel));

    p_bad_div_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_div > DIV_W'(DIV_MAX)) |=> $stable(div_code));

    p_ready_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !ready);
endmodule

// File: rtl/ckctl_mux.sv
// Glitch-free N-input clock multiplexer. Each input has a two-stage enable:
// the first stage samples on that input's rising edge, the second on its falling
// edge, so an enable only changes while its own clock is low. An input may
// request enable only when all other enables are low.
// Assumes every input clock keeps running and that reset spans several cycles
// of the slowest input.
module ckctl_mux import ckctl_pkg::*; (
    input  logic [NUM_SRC-1:0] clk_in,
    input  logic               rst_n,
    input  logic [SRC_W-1:0]   sel,
    output logic               main_clk,
    output logic [NUM_SRC-1:0] en
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_leg
        localparam logic [SRC_W-1:0]   IDX    = SRC_W'(i);
        localparam logic [NUM_SRC-1:0] OTHERS = ~(NUM_SRC'(1) << i);
        localparam logic               RST_ON = (i == 0) ? 1'b1 : 1'b0;
        logic ck;
        logic req_q;
        logic en_q;

        assign ck = clk_in[i];

        // Stage 1: request this leg when selected and every other leg is off.
        always_ff @(posedge ck) begin
            if (!rst_n) req_q <= RST_ON;
            else        req_q <= (sel == IDX) && !(|(en & OTHERS));
        end

        // Stage 2: commit the enable while this clock is low.
        always_ff @(negedge ck) begin
            if (!rst_n) en_q <= RST_ON;
            else        en_q <= req_q;
        end

        assign en[i] = en_q;
    end

    assign main_clk = |(clk_in & en);

    p_single_src_r7: assert property (@(posedge clk_in[0]) disable iff (!rst_n)
        $onehot0(en));
endmodule

// File: rtl/ckctl_div.sv
// Power-of-two prescaler running on the main clock. A down-counter marks one
// main cycle in every 2^code. An enable register, updated on the falling edge,
// passes that cycle's high phase to the output. The divide code arrives from
// another domain. It is accepted once two synchronised samples agree, and it
// is loaded only when the counter wraps.
module ckctl_div import ckctl_pkg::*; (
    input  logic             main_clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_code,
    output logic             sys_clk,
    output logic [DIV_W-1:0] div_act
);
    logic [DIV_W-1:0] code_s1;
    logic [DIV_W-1:0] code_s2;
    logic [DIV_W-1:0] code_s3;
    logic [DIV_W-1:0] next_code;
    logic [CNT_W:0]   span;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] cnt;
    logic             gate;

    // Bring the divide code into the main-clock domain.
    always_ff @(posedge main_clk) begin
        if (!rst_n) begin
            code_s1 <= DIV_RST;
            code_s2 <= DIV_RST;
            code_s3 <= DIV_RST;
        end else begin
            code_s1 <= div_code;
            code_s2 <= code_s1;
            code_s3 <= code_s2;
        end
    end

    // Pick the code for the next period and its counter reload value.
    always_comb begin
        next_code = (code_s2 == code_s3) ? code_s3 : div_act;
        span      = (CNT_W + 1)'(1) << next_code;
        reload    = span[CNT_W-1:0] - CNT_W'(1);
    end

    // Period counter; the ratio changes only at the wrap.
    always_ff @(posedge main_clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            div_act <= DIV_RST;
        end else if (cnt == '0) begin
            cnt     <= reload;
            div_act <= next_code;
        end else begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    // Output enable, changed only while the main clock is low.
    always_ff @(negedge main_clk) begin
        if (!rst_n) gate <= 1'b0;
        else        gate <= (cnt == '0);
    end

    assign sys_clk = main_clk & gate;

    p_ratio_at_wrap_r8: assert property (@(posedge main_clk) disable iff (!rst_n)
        (div_act != $past(div_act)) |-> $past(cnt == '0));
endmodule

// File: rtl/clk_switch_div.sv
// Top level: configuration registers, glitch-free source mux and prescaler.
// Assumes all three clocks run freely with about 50 % duty, and that rst_n is
// synchronous to clk_fast and held for several slow-clock periods.
module clk_switch_div import ckctl_pkg::*; (
    input  logic             clk_fast,
    input  logic             clk_slow,
    input  logic             clk_ext,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SRC_W-1:0] wr_src,
    input  logic [DIV_W-1:0] wr_div,
    output logic             sys_clk,
    output logic             ready
);
    logic [SRC_W-1:0]   sel;
    logic [DIV_W-1:0]   div_code;
    logic [DIV_W-1:0]   div_act;
    logic [NUM_SRC-1:0] en;
    logic [NUM_SRC-1:0] clk_in;
    logic               main_clk;

    assign clk_in = {clk_ext, clk_slow, clk_fast};

    ckctl_cfg u_cfg (
        .clk      (clk_fast),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_src   (wr_src),
        .wr_div   (wr_div),
        .en_ack   (en),
        .div_act  (div_act),
        .sel      (sel),
        .div_code (div_code),
        .ready    (ready)
    );

    ckctl_mux u_mux (
        .clk_in   (clk_in),
        .rst_n    (rst_n),
        .sel      (sel),
        .main_clk (main_clk),
        .en       (en)
    );

    ckctl_div u_div (
        .main_clk (main_clk),
        .rst_n    (rst_n),
        .div_code (div_code),
        .sys_clk  (sys_clk),
        .div_act  (div_act)
    );
endmodule

// File: tb/clk_switch_div_tb.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module clk_switch_div_tb;
    logic       clk_fast = 1'b0;
    logic       clk_slow = 1'b0;
    logic       clk_ext  = 1'b0;
    logic       rst_n    = 1'b0;
    logic       wr_en    = 1'b0;
    logic [1:0] wr_src   = 2'd0;
    logic [3:0] wr_div   = 4'd0;
    logic       sys_clk;
    logic       ready;

    int  checks = 0;
    int  errors = 0;
    int  m_src  = 0;
    int  m_div  = 3;
    real src_per [3] = '{8.0, 40.0, 24.0};

    real last_rise   = 0.0;
    bit  have_rise   = 1'b0;
    real last_period = 0.0;
    real min_period  = 1.0e9;
    real min_high    = 1.0e9;
    bit  member_on   = 1'b0;
    real mem_a       = 0.0;
    real mem_b       = 0.0;
    int  member_bad  = 0;
    real bad_val     = 0.0;

    clk_switch_div u_dut (
        .clk_fast (clk_fast),
        .clk_slow (clk_slow),
        .clk_ext  (clk_ext),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_src   (wr_src),
        .wr_div   (wr_div),
        .sys_clk  (sys_clk),
        .ready    (ready)
    );

    always #4 clk_fast = ~clk_fast;
    always #20 clk_slow = ~clk_slow;
    initial begin
        #3;
        forever #12 clk_ext = ~clk_ext;
    end

    // Period monitor on the system clock.
    always @(posedge sys_clk) begin
        if (have_rise) begin
            last_period = $realtime - last_rise;
            if (last_period < min_period) min_period = last_period;
            if (member_on && (last_period > mem_a + 0.01 || last_period < mem_a - 0.01) &&
                (last_period > mem_b + 0.01 || last_period < mem_b - 0.01)) begin
                member_bad++;
                bad_val = last_period;
            end
        end
        last_rise = $realtime;
        have_rise = 1'b1;
    end

    // High-phase monitor.
    always @(negedge sys_clk) begin
        if (have_rise && ($realtime - last_rise) < min_high) min_high = $realtime - last_rise;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input real act, input real exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0.3f expected %0.3f", req, what, act, exp);
        end
    endtask

    function automatic real exp_period(input int s, input int d);
        return src_per[s] * real'(1 << d);
    endfunction

    function automatic real rmin(input real a, input real b);
        return (a < b) ? a : b;
    endfunction

    task automatic wait_ready(input string req);
        for (int k = 0; k < 4000 && !ready; k++) @(negedge clk_fast);
        check(ready == 1'b1, req, "ready returns after request", real'(ready), 1.0);
    endtask

    task automatic measure(input string req, input real exp);
        repeat (3) @(posedge sys_clk);
        @(posedge sys_clk);
        #1;
        check(last_period > exp - 0.01 && last_period < exp + 0.01, req,
              "steady system period", last_period, exp);
    endtask

    // One configuration write plus the checks on the transition it causes.
    task automatic apply(input int src, input int div, input string req);
        real old_p;
        real new_p;
        int  old_s;
        real half_min;
        old_p = exp_period(m_src, m_div);
        old_s = m_src;
        if (src < 3) m_src = src;
        if (div <= 8) m_div = div;
        new_p = exp_period(m_src, m_div);
        half_min   = rmin(src_per[old_s], src_per[m_src]) / 2.0;
        min_period = 1.0e9;
        min_high   = 1.0e9;
        member_bad = 0;
        mem_a      = old_p;
        mem_b      = new_p;
        member_on  = (old_s == m_src);
        @(negedge clk_fast);
        wr_en  = 1'b1;
        wr_src = 2'(src);
        wr_div = 4'(div);
        @(negedge clk_fast);
        wr_en = 1'b0;
        check(ready == 1'b0, "R9", "ready low after write", real'(ready), 0.0);
        wait_ready("R9");
        measure(req, new_p);
        check(min_period >= rmin(old_p, new_p) - 0.01, "R6",
              "shortest period across change", min_period, rmin(old_p, new_p));
        check(min_high >= half_min - 0.01, "R7",
              "shortest high phase across change", min_high, half_min);
        if (member_on)
            check(member_bad == 0, "R8", "ratio-change period neither old nor new",
                  bad_val, new_p);
        member_on = 1'b0;
    endtask

    task automatic t_reset();
        repeat (30) @(negedge clk_fast);
        check(ready == 1'b0, "R1", "ready low during reset", real'(ready), 0.0);
        rst_n = 1'b1;
        wait_ready("R1");
        measure("R1", 64.0);
    endtask

    task automatic t_divide();
        apply(0, 0, "R4");
        apply(0, 4, "R4");
        apply(0, 8, "R4");
        apply(0, 9, "R5");
        apply(0, 15, "R5");
        apply(0, 2, "R4");
    endtask

    task automatic t_source();
        apply(1, 2, "R2");
        apply(2, 2, "R2");
        apply(3, 2, "R3");
        apply(3, 1, "R3");
        apply(1, 0, "R2");
        apply(0, 0, "R2");
        apply(2, 3, "R2");
    endtask

    initial begin
        t_reset();
        t_divide();
        t_source();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk_fast);
        checks++;
        errors++;
        $display("FAIL R9 watchdog expired: actual %0d expected %0d", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule